// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block takes an asynchronous serial line and turns it back into characters. A one-cycle enable, `tick`, sets the sampling rate. Each bit lasts 16 ticks, or 8 ticks when the double-speed option is set. The line first passes through a two-flop synchronizer. While the receiver is idle, a low sample on a tick starts a frame. Every bit is then decided by a majority vote of three samples taken around its center, so a one-sample glitch does not flip a bit. If the vote on the start bit comes out high, the start is dropped as false and the receiver goes back to waiting for a low level.

The frame format is set at run time by the configuration inputs. Data is 5 to 9 bits, least significant bit first. Parity is none, even or odd. Only the first stop bit is checked. Finished characters go into a receive queue that is two entries deep, or one entry deep when the single-level option is set. Each entry holds its own framing, parity and overrun flags, and a read removes the oldest entry. In address-filter mode, 9-bit frames whose top bit is clear are thrown away, so the host only sees address frames until it turns the mode off.

Top module: `osr_uart_rx`

## Requirements
- R1: After reset the queue is empty (`rd_valid` low) and the receiver is idle.
- R2: A frame is one low start bit, then `cfg_dbits` data bits sent least significant bit first, then a high stop bit. `cfg_dbits` runs from 5 to 9; values below 5 act as 5 and values above 9 act as 9. The character is stored right-aligned in `rd_data[8:0]`, with the unused upper bits at zero.
- R3: `cfg_par` selects the parity: 2'b10 is even, 2'b11 is odd, and 2'b00 or 2'b01 means no parity bit. When enabled, the parity bit follows the data. If it differs from the XOR of the data bits (inverted for odd parity), the entry's `rd_perr` is set.
- R4: If the vote on the first stop bit is low, the entry's `rd_ferr` is set, and the receiver is idle one cycle after that vote.
- R5: If the start bit's center vote is high, the frame is abandoned with nothing stored, and the receiver is idle on the next cycle.
- R6: Each bit is the majority of three consecutive samples. These are samples 7, 8 and 9 of the bit (counting from 0) at 16x, and samples 3, 4 and 5 at 8x. A single wrong sample among them does not change the bit.
- R7: With `cfg_dbl` high, each bit lasts 8 ticks instead of 16.
- R8: The queue holds up to two characters. `rd_pop` while `rd_valid` is high removes the oldest entry, so characters come out in arrival order.
- R9: If a frame completes while the queue is full and no pop happens in that cycle, the new character is dropped, the stored ones are kept, and `rd_ovr` is set on the newest stored entry.
- R10: With `cfg_single` high the queue holds only one character, and overrun works as in R9 with that single entry.
- R11: With `cfg_mpcm` high and 9 data bits, a frame whose bit 8 is 0 is discarded and leaves the queue unchanged. A frame whose bit 8 is 1 is stored.
- R12: The receiver moves on only in cycles where `tick` is high. Any tick spacing gives the same characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Oversampling enable |
| rx | input | 1 | Serial line, asynchronous |
| cfg_dbits | input | 4 | Number of data bits (5 to 9) |
| cfg_par | input | 2 | Parity mode: 10 even, 11 odd, 0x none |
| cfg_dbl | input | 1 | Double speed, 8 ticks per bit |
| cfg_single | input | 1 | Single-level queue |
| cfg_mpcm | input | 1 | Address-filter mode |
| rd_pop | input | 1 | Remove the oldest entry |
| rd_valid | output | 1 | Queue not empty |
| rd_data | output | 9 | Oldest character |
| rd_ferr | output | 1 | Framing error of the oldest entry |
| rd_perr | output | 1 | Parity error of the oldest entry |
| rd_ovr | output | 1 | A character was lost after this entry |

## Verification
The bench sends a start pulse that is too short; a receiver that does not recheck the start would store a garbage character. It puts a one-tick glitch at the center of a data bit; a receiver that takes a single sample would flip that bit. It sends three frames with no reads in between, once with the two-entry queue and once with the single-level queue. A design that overwrote entries or flagged the wrong entry would give back the newest character or misplace `rd_ovr`. It sends address and data frames in filter mode, checks parity in both senses, checks a low stop bit, and runs at double speed and with a slow tick. Wrong bit timing would garble these characters.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;
  localparam int MAX_BITS = 9;
  localparam int MIN_BITS = 5;

  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic                ferr;
    logic                perr;
    logic                ovr;
  } rx_entry_t;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} rx_state_t;

  // two-of-three vote
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // bring the configured length into the supported range
  function automatic logic [3:0] clamp_bits(input logic [3:0] n);
    if (n < 4'(MIN_BITS)) return 4'(MIN_BITS);
    if (n > 4'(MAX_BITS)) return 4'(MAX_BITS);
    return n;
  endfunction

  // expected parity bit; unused data bits are zero so the full XOR is safe
  function automatic logic parity_of(input logic [MAX_BITS-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction
endpackage

// File: rtl/rx_sync2.sv
module rx_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import osr_rx_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rxs,
  input  logic                dbl,
  input  logic [3:0]          nbits,
  input  logic                par_en,
  input  logic                par_odd,
  output logic                busy,
  output logic                done,
  output logic                false_start,
  output logic                ferr,
  output logic                perr,
  output logic [MAX_BITS-1:0] data
);
  localparam logic [CW-1:0] LAST_N = CW'((1 << CW) - 1);
  localparam logic [CW-1:0] LAST_D = CW'((1 << (CW-1)) - 1);
  localparam logic [CW-1:0] VOTE_N = CW'((1 << (CW-1)) - 1);
  localparam logic [CW-1:0] VOTE_D = CW'((1 << (CW-2)) - 1);

  rx_state_t           st;
  logic [CW-1:0]       scnt;
  logic [3:0]          bidx;
  logic [1:0]          vs;
  logic [MAX_BITS-1:0] dat_q;
  logic                perr_q;

  logic [CW-1:0] last_i, vote_lo, vote_hi;
  logic          vote_now, bit_end, maj;

  assign last_i   = dbl ? LAST_D : LAST_N;
  assign vote_lo  = dbl ? VOTE_D : VOTE_N;
  assign vote_hi  = vote_lo + CW'(2);
  assign vote_now = tick && (st != ST_IDLE) && (scnt == vote_hi);
  assign bit_end  = tick && (st != ST_IDLE) && (scnt == last_i);
  assign maj      = vote3(vs[0], vs[1], rxs);

  assign false_start = vote_now && (st == ST_START) && maj;
  assign done        = vote_now && (st == ST_STOP);
  assign ferr        = !maj;
  assign perr        = perr_q;
  assign data        = dat_q;
  assign busy        = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      scnt   <= '0;
      bidx   <= '0;
      vs     <= '1;
      dat_q  <= '0;
      perr_q <= 1'b0;
    end else if (tick) begin
      if (st == ST_IDLE) begin
        if (!rxs) begin
          st     <= ST_START;
          scnt   <= CW'(1);
          dat_q  <= '0;
          perr_q <= 1'b0;
        end
      end else begin
        scnt <= (scnt == last_i) ? '0 : scnt + CW'(1);
        if (scnt == vote_lo)         vs[0] <= rxs;
        if (scnt == vote_lo + CW'(1)) vs[1] <= rxs;
        if (vote_now) begin
          unique case (st)
            ST_START: if (maj) st <= ST_IDLE;
            ST_DATA:  dat_q[bidx] <= maj;
            ST_PAR:   perr_q <= (maj != parity_of(dat_q, par_odd));
            ST_STOP:  st <= ST_IDLE;
            default:  ;
          endcase
        end
        if (bit_end) begin
          unique case (st)
            ST_START: begin st <= ST_DATA; bidx <= '0; end
            ST_DATA: begin
              if (bidx == nbits - 4'd1) st <= par_en ? ST_PAR : ST_STOP;
              else                      bidx <= bidx + 4'd1;
            end
            ST_PAR:  st <= ST_STOP;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/rx_queue2.sv
module rx_queue2
  import osr_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      single,
  input  logic      push,
  input  rx_entry_t wentry,
  input  logic      pop,
  input  logic      mark_ovr,
  output logic      full,
  output logic [1:0] cnt,
  output rx_entry_t rentry
);
  localparam int DEPTH = 2;

  rx_entry_t ent [DEPTH];
  logic      wp, rp;

  assign full   = single ? (cnt >= 2'd1) : (cnt == 2'(DEPTH));
  assign rentry = ent[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= 1'b0;
      rp  <= 1'b0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else begin
      if (push) begin
        ent[wp] <= wentry;
        wp      <= ~wp;
      end
      if (mark_ovr) ent[~wp].ovr <= 1'b1;
      if (pop) rp <= ~rp;
      cnt <= cnt + {1'b0, push} - {1'b0, pop};
    end
  end
endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
  import osr_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rx,
  input  logic [3:0]          cfg_dbits,
  input  logic [1:0]          cfg_par,
  input  logic                cfg_dbl,
  input  logic                cfg_single,
  input  logic                cfg_mpcm,
  input  logic                rd_pop,
  output logic                rd_valid,
  output logic [MAX_BITS-1:0] rd_data,
  output logic                rd_ferr,
  output logic                rd_perr,
  output logic                rd_ovr
);
  logic                rxs, busy, frame_done, false_start, f_ferr, f_perr;
  logic [MAX_BITS-1:0] f_data;
  logic [3:0]          nbits;
  logic                q_full, pop, push, drop_ovr, mp_discard, accept;
  logic [1:0]          q_cnt;
  rx_entry_t           wentry, rentry;

  assign nbits = clamp_bits(cfg_dbits);

  rx_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx), .q(rxs)
  );

  rx_framer #(.CW(CNT_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxs(rxs), .dbl(cfg_dbl),
    .nbits(nbits), .par_en(cfg_par[1]), .par_odd(cfg_par[0]),
    .busy(busy), .done(frame_done), .false_start(false_start),
    .ferr(f_ferr), .perr(f_perr), .data(f_data)
  );

  assign mp_discard = frame_done && cfg_mpcm && (nbits == 4'd9) && !f_data[8];
  assign accept     = frame_done && !mp_discard;
  assign pop        = rd_pop && rd_valid;
  assign push       = accept && !(q_full && !pop);
  assign drop_ovr   = accept && q_full && !pop;
  assign wentry     = '{data: f_data, ferr: f_ferr, perr: f_perr, ovr: 1'b0};

  rx_queue2 u_queue (
    .clk(clk), .rst_n(rst_n), .single(cfg_single), .push(push), .wentry(wentry),
    .pop(pop), .mark_ovr(drop_ovr), .full(q_full), .cnt(q_cnt), .rentry(rentry)
  );

  assign rd_valid = (q_cnt != 2'd0);
  assign rd_data  = rentry.data;
  assign rd_ferr  = rentry.ferr;
  assign rd_perr  = rentry.perr;
  assign rd_ovr   = rentry.ovr;
endmodule

// File: rtl/osr_uart_rx_chk.sv
module osr_uart_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       busy,
  input logic       false_start,
  input logic       frame_done,
  input logic       push,
  input logic       pop,
  input logic       drop_ovr,
  input logic       mp_discard,
  input logic [1:0] q_cnt,
  input logic       cfg_single,
  input logic       rd_valid
);
  assert_cap_R8: assert property (@(posedge clk) disable iff (!rst_n) q_cnt <= 2'd2);
  assert_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_single && q_cnt <= 2'd1) |=> (!cfg_single || q_cnt <= 2'd1));
  assert_false_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    false_start |=> !busy);
  assert_stop_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);
  assert_ovr_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ovr |=> (rd_valid && $stable(q_cnt)));
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push, drop_ovr, mp_discard}));
  assert_mp_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mp_discard && !pop) |=> $stable(q_cnt));
  assert_pop_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && q_cnt == 2'd1) |=> !rd_valid);
  assert_tick_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(busy));
endmodule

bind osr_uart_rx osr_uart_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy), .false_start(false_start),
  .frame_done(frame_done), .push(push), .pop(pop), .drop_ovr(drop_ovr),
  .mp_discard(mp_discard), .q_cnt(q_cnt), .cfg_single(cfg_single), .rd_valid(rd_valid)
);

// File: tb/osr_uart_rx_tb.sv
module osr_uart_rx_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rx = 1'b1;
  logic [3:0] cfg_dbits = 4'd8;
  logic [1:0] cfg_par = 2'b00;
  logic       cfg_dbl = 1'b0, cfg_single = 1'b0, cfg_mpcm = 1'b0, rd_pop = 1'b0;
  logic       rd_valid, rd_ferr, rd_perr, rd_ovr;
  logic [8:0] rd_data;

  int n_checks = 0, n_fail = 0, tick_cnt = 0, tick_div = 1, phase = 0, osr = 16;
  bit finished = 0;

  osr_uart_rx u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx), .cfg_dbits(cfg_dbits),
    .cfg_par(cfg_par), .cfg_dbl(cfg_dbl), .cfg_single(cfg_single), .cfg_mpcm(cfg_mpcm),
    .rd_pop(rd_pop), .rd_valid(rd_valid), .rd_data(rd_data), .rd_ferr(rd_ferr),
    .rd_perr(rd_perr), .rd_ovr(rd_ovr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick  <= (phase == 0);
    phase <= (phase + 1 >= tick_div) ? 0 : phase + 1;
  end
  always @(posedge clk) if (tick) tick_cnt <= tick_cnt + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    int target;
    rx = lvl;
    target = tick_cnt + n;
    while (tick_cnt < target) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx = 1'b1; rd_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // pmode: 0 none, 2 even, 3 odd; glitch_bit: data bit index with one flipped centre sample, -1 none
  task automatic send(input int d, input int nb, input int pmode, input bit bad_par,
                      input logic stop_lvl, input int glitch_bit);
    logic [8:0] dm;
    logic       p;
    dm = 9'(d) & 9'((1 << nb) - 1);
    hold(1'b0, osr);
    for (int i = 0; i < nb; i++) begin
      if (i == glitch_bit) begin
        hold(dm[i], osr/2);
        hold(~dm[i], 1);
        hold(dm[i], osr/2 - 1);
      end else hold(dm[i], osr);
    end
    if (pmode >= 2) begin
      p = (^dm) ^ pmode[0] ^ bad_par;
      hold(p, osr);
    end
    hold(stop_lvl, osr);
    hold(1'b1, 2*osr);
  endtask

  task automatic expect_pop(input string req, input int d, input bit fe, input bit pe, input bit ov);
    @(negedge clk);
    check(rd_valid == 1'b1, req, "valid", rd_valid, 1);
    check(rd_data == 9'(d), req, "data", rd_data, d);
    check(rd_ferr == fe, req, "ferr", rd_ferr, fe);
    check(rd_perr == pe, req, "perr", rd_perr, pe);
    check(rd_ovr == ov, req, "ovr", rd_ovr, ov);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    check(rd_valid == 1'b0, req, "empty", rd_valid, 0);
  endtask

  task automatic t_reset();
    do_reset();
    expect_empty("R1");
  endtask

  task automatic t_formats();
    cfg_dbits = 4'd8; send('hA5, 8, 0, 0, 1'b1, -1); expect_pop("R2", 'hA5, 0, 0, 0);
    cfg_dbits = 4'd5; send('h13, 5, 0, 0, 1'b1, -1); expect_pop("R2", 'h13, 0, 0, 0);
    cfg_dbits = 4'd9; send('h1C6, 9, 0, 0, 1'b1, -1); expect_pop("R2", 'h1C6, 0, 0, 0);
    cfg_dbits = 4'd2; send('h0B, 5, 0, 0, 1'b1, -1); expect_pop("R2", 'h0B, 0, 0, 0);
    cfg_dbits = 4'd8;
  endtask

  task automatic t_parity();
    cfg_dbits = 4'd7; cfg_par = 2'b10;
    send('h5A, 7, 2, 0, 1'b1, -1); expect_pop("R3", 'h5A, 0, 0, 0);
    send('h5B, 7, 2, 1, 1'b1, -1); expect_pop("R3", 'h5B, 0, 1, 0);
    cfg_par = 2'b11;
    send('h21, 7, 3, 0, 1'b1, -1); expect_pop("R3", 'h21, 0, 0, 0);
    send('h21, 7, 3, 1, 1'b1, -1); expect_pop("R3", 'h21, 0, 1, 0);
    cfg_par = 2'b00; cfg_dbits = 4'd8;
  endtask

  task automatic t_frame_err();
    send('h3C, 8, 0, 0, 1'b0, -1); expect_pop("R4", 'h3C, 1, 0, 0);
    expect_empty("R4");
    send('h81, 8, 0, 0, 1'b1, -1); expect_pop("R4", 'h81, 0, 0, 0);
  endtask

  task automatic t_false_start();
    hold(1'b0, 4);
    hold(1'b1, 3*osr);
    expect_empty("R5");
    send('h66, 8, 0, 0, 1'b1, -1); expect_pop("R5", 'h66, 0, 0, 0);
  endtask

  task automatic t_glitch();
    send('hF0, 8, 0, 0, 1'b1, 2); expect_pop("R6", 'hF0, 0, 0, 0);
    send('h0F, 8, 0, 0, 1'b1, 5); expect_pop("R6", 'h0F, 0, 0, 0);
  endtask

  task automatic t_double();
    do_reset(); cfg_dbl = 1'b1; osr = 8;
    send('hC3, 8, 0, 0, 1'b1, -1); expect_pop("R7", 'hC3, 0, 0, 0);
    send('h5C, 8, 0, 0, 1'b1, 3); expect_pop("R7", 'h5C, 0, 0, 0);
    do_reset(); cfg_dbl = 1'b0; osr = 16;
  endtask

  task automatic t_queue();
    do_reset();
    send('h11, 8, 0, 0, 1'b1, -1);
    send('h22, 8, 0, 0, 1'b1, -1);
    send('h33, 8, 0, 0, 1'b1, -1);
    expect_pop("R8", 'h11, 0, 0, 0);
    expect_pop("R9", 'h22, 0, 0, 1);
    expect_empty("R9");
  endtask

  task automatic t_single();
    do_reset(); cfg_single = 1'b1;
    send('h44, 8, 0, 0, 1'b1, -1);
    send('h55, 8, 0, 0, 1'b1, -1);
    expect_pop("R10", 'h44, 0, 0, 1);
    expect_empty("R10");
    do_reset(); cfg_single = 1'b0;
  endtask

  task automatic t_mpcm();
    do_reset(); cfg_mpcm = 1'b1; cfg_dbits = 4'd9;
    send('h055, 9, 0, 0, 1'b1, -1);
    expect_empty("R11");
    send('h1A3, 9, 0, 0, 1'b1, -1);
    expect_pop("R11", 'h1A3, 0, 0, 0);
    expect_empty("R11");
    cfg_mpcm = 1'b0;
    send('h055, 9, 0, 0, 1'b1, -1);
    expect_pop("R11", 'h055, 0, 0, 0);
    cfg_dbits = 4'd8;
  endtask

  task automatic t_slow_tick();
    do_reset(); tick_div = 3;
    send('h96, 8, 0, 0, 1'b1, 4); expect_pop("R12", 'h96, 0, 0, 0);
    tick_div = 1;
  endtask

  initial begin
    t_reset();
    t_formats();
    t_parity();
    t_frame_err();
    t_false_start();
    t_glitch();
    t_double();
    t_queue();
    t_single();
    t_mpcm();
    t_slow_tick();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule